// File: doc/BRIEF.md
# UART Transmit FIFO Interrupt Holder

This block sits between a host that writes transmit bytes and a UART transmit shift register that takes them one at a time. Bytes are kept in a 16-entry, 8-bit FIFO. The shift register takes a byte through a ready/valid handshake. A 4-bit trigger field sets a batch size of field value plus one. Each time a full batch has left the FIFO, a "transmit enable" condition is raised, and the host is expected to answer each interrupt by writing exactly one batch.

In plain mode, every condition produces a one-clock interrupt pulse straight away. In pending mode, the block tracks whether the host still owes the refill for an interrupt it has already issued. Conditions that arrive while a refill is owed are counted rather than signalled. Each counted condition is issued on the clock after the host finishes the owed batch. Because the FIFO is only 16 entries deep, the count has a ceiling that depends on the batch size. Surplus writes and writes into a full FIFO are recorded in sticky error bits.

The controller has three states. `ST_PRIME` covers the time after reset, or in plain mode, while the host may fill freely. `ST_OWED` means an interrupt has been issued and its batch is not yet complete. `ST_SETTLED` means every issued batch has been written and nothing is owed. The transitions are as follows:
- PRIME→OWED and SETTLED→OWED: a condition fires.
- OWED→OWED: a batch completes while holds remain.
- OWED→SETTLED: a batch completes with nothing held.
- any state→PRIME: plain mode is selected.

Top module: `txpend_ctrl`

## Requirements
- R1: The batch size is `trig_sel`+1 bytes. A byte is transferred in a cycle where `ld_ready` and `ld_valid` are both 1. The condition is met on every transfer that brings the count of transferred bytes to a whole multiple of the batch size, counted from reset. When the condition leads to an interrupt, `irq` is 1 in the cycle after that transfer.
- R2: The FIFO delivers bytes in write order. `ld_valid` is 1 exactly when the FIFO is not empty, and `ld_data` shows the oldest byte. `fifo_full` is 1 at 16 stored bytes and `fifo_empty` is 1 at none. In a cycle where the FIFO is full, a write is refused even if a byte leaves in the same cycle.
- R3: A write (`wr_valid`=1) while `fifo_full`=1 is discarded. The refused byte never appears on `ld_data`, and `ovf_err` becomes 1 on the next cycle and stays 1 until reset.
- R4: With `pend_mode`=0, every met condition gives exactly one one-cycle `irq` pulse, and nothing is held.
- R5: With `pend_mode`=1 and no refill owed, a met condition gives an `irq` pulse, and the refill for it becomes owed. A condition met while a refill is owed gives no pulse and is counted as held.
- R6: While a refill is owed, accepted writes count toward it. The write that makes the count equal to the batch size completes it. If any interrupt is held, one is issued on the next cycle and becomes the new owed refill. If none is held, nothing remains owed.
- R7: At most floor(16 / batch size) − 1 interrupts are held. This is 15 for a 1-byte batch, 7 for 2 bytes, 1 for 6 to 8 bytes, and 0 for batches of 9 bytes or more. Conditions beyond the limit are dropped.
- R8: Several conditions that fall due from one large fill are each evaluated and counted separately, one per completed batch.
- R9: In pending mode, once a refill has completed and nothing is owed, any further accepted write sets the sticky `batch_err`. Writes made before the first interrupt after reset do not set it.
- R10: While `rst` is high on a clock edge, the block empties the FIFO, clears the transfer and write counts, the hold count, `irq`, `ovf_err` and `batch_err`, and returns to `ST_PRIME`.
- R11: When a refill completes in the same cycle that a condition is met, exactly one `irq` pulse follows on the next cycle, and the hold count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host write byte |
| pend_mode | input | 1 | 1 selects pending mode, 0 selects plain mode |
| trig_sel | input | 4 | Batch size minus one |
| ld_ready | input | 1 | Shift register can take a byte |
| ld_valid | output | 1 | FIFO holds a byte |
| ld_data | output | 8 | Oldest FIFO byte |
| fifo_full | output | 1 | FIFO holds 16 bytes |
| fifo_empty | output | 1 | FIFO holds no byte |
| irq | output | 1 | Transmit enable interrupt pulse |
| ovf_err | output | 1 | Sticky flag for a write refused while full |
| batch_err | output | 1 | Sticky flag for a surplus write in pending mode |

## Verification
The bench builds the block with its default parameters: 8-bit data and a 4-bit trigger field, which gives 16 FIFO entries. With these values every batch size from 1 to 16 bytes can be selected. This puts within reach the hold ceilings of 15 and 7, the single-hold ceiling, and the zero ceiling at which late conditions are dropped. It also lets one full FIFO drain raise a long run of back-to-back conditions.

// File: rtl/txpend_pkg.sv
package txpend_pkg;

    typedef enum logic [1:0] {
        ST_PRIME   = 2'd0,
        ST_SETTLED = 2'd1,
        ST_OWED    = 2'd2
    } txp_state_e;

    // floor(depth / batch) - 1, computed with a running sum instead of a divider
    function automatic int unsigned hold_cap(input int unsigned depth,
                                             input int unsigned batch);
        int unsigned fits;
        int unsigned acc;
        fits = 0;
        acc  = batch;
        for (int unsigned i = 1; i <= 64; i++) begin
            if (i <= depth && acc <= depth) fits = i;
            acc = acc + batch;
        end
        return (fits == 0) ? 0 : fits - 1;
    endfunction

endpackage

// File: rtl/txpend_fifo.sv
module txpend_fifo #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: a refused write leaves a full FIFO full
    a_r3_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full);
    // R2: no byte appears from nowhere
    a_r2_empty_holds: assert property (@(posedge clk) disable iff (rst)
        (empty && !push) |=> empty);

endmodule

// File: rtl/txpend_batch_ctr.sv
module txpend_batch_ctr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] last_idx,
    output logic          tick
);
    logic [CW-1:0] cnt;

    assign tick = inc && !clr && (cnt == last_idx);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (tick)   cnt <= '0;
        else if (inc)    cnt <= cnt + 1'b1;
    end

    // R8: every completed batch restarts the count for the next one
    a_r8_tick_restarts: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));

endmodule

// File: rtl/txpend_ctrl.sv
module txpend_ctrl #(
    parameter int DW     = 8,
    parameter int TRIG_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DW-1:0]     wr_data,
    input  logic              pend_mode,
    input  logic [TRIG_W-1:0] trig_sel,
    input  logic              ld_ready,
    output logic              ld_valid,
    output logic [DW-1:0]     ld_data,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              irq,
    output logic              ovf_err,
    output logic              batch_err
);
    import txpend_pkg::*;

    localparam int DEPTH = 1 << TRIG_W;

    txp_state_e        state, state_n;
    logic [TRIG_W-1:0] pend_cnt, pend_n, hold_max;
    logic              push_ok, pop_ok, xfer_tick, wr_done;
    logic              fire, berr_set;

    assign push_ok  = wr_valid && !fifo_full;
    assign pop_ok   = ld_ready && !fifo_empty;
    assign ld_valid = !fifo_empty;
    assign hold_max = TRIG_W'(hold_cap(DEPTH, int'(trig_sel) + 1));

    txpend_fifo #(.DW(DW), .AW(TRIG_W)) u_fifo (
        .clk(clk), .rst(rst),
        .push(wr_valid), .din(wr_data),
        .pop(ld_ready), .dout(ld_data),
        .full(fifo_full), .empty(fifo_empty)
    );

    txpend_batch_ctr #(.CW(TRIG_W)) u_xfer_ctr (
        .clk(clk), .rst(rst), .clr(1'b0),
        .inc(pop_ok), .last_idx(trig_sel), .tick(xfer_tick)
    );

    txpend_batch_ctr #(.CW(TRIG_W)) u_wr_ctr (
        .clk(clk), .rst(rst),
        .clr(!pend_mode || (state != ST_OWED)),
        .inc(push_ok), .last_idx(trig_sel), .tick(wr_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_PRIME;
            pend_cnt <= '0;
        end else begin
            state    <= state_n;
            pend_cnt <= pend_n;
        end
    end

    // next state and decisions
    always_comb begin
        state_n  = state;
        pend_n   = pend_cnt;
        fire     = 1'b0;
        berr_set = 1'b0;
        if (!pend_mode) begin
            state_n = ST_PRIME;
            pend_n  = '0;
            fire    = xfer_tick;
        end else begin
            unique case (state)
                ST_PRIME, ST_SETTLED: begin
                    if (state == ST_SETTLED && push_ok) berr_set = 1'b1;
                    if (xfer_tick) begin
                        fire    = 1'b1;
                        state_n = ST_OWED;
                    end
                end
                ST_OWED: begin
                    if (wr_done) begin
                        if (pend_cnt != '0 || xfer_tick) begin
                            fire   = 1'b1;
                            pend_n = xfer_tick ? pend_cnt : pend_cnt - 1'b1;
                        end else begin
                            state_n = ST_SETTLED;
                        end
                    end else if (xfer_tick && (pend_cnt < hold_max)) begin
                        pend_n = pend_cnt + 1'b1;
                    end
                end
                default: state_n = ST_PRIME;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            irq       <= 1'b0;
            ovf_err   <= 1'b0;
            batch_err <= 1'b0;
        end else begin
            irq <= fire;
            if (wr_valid && fifo_full) ovf_err   <= 1'b1;
            if (berr_set)              batch_err <= 1'b1;
        end
    end

    // R3: refused write is flagged and the flag sticks
    a_r3_ovf_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && fifo_full) |=> ovf_err);
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err);
    // R7: hold count never passes the ceiling
    a_r7_hold_ceiling: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= hold_max);
    // R4: plain mode keeps nothing held
    a_r4_plain_no_hold: assert property (@(posedge clk) disable iff (rst)
        !pend_mode |=> (pend_cnt == '0));
    // R6: each pulse follows a completed transfer batch or a completed refill
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(xfer_tick || wr_done));
    // R9: surplus-write flag sticks
    a_r9_berr_sticky: assert property (@(posedge clk) disable iff (rst)
        batch_err |=> batch_err);

endmodule

// File: tb/txpend_ctrl_bench.sv
module txpend_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       pend_mode = 1'b0;
    logic [3:0] trig_sel = '0;
    logic       ld_ready = 1'b0;
    logic       ld_valid, fifo_full, fifo_empty, irq, ovf_err, batch_err;
    logic [7:0] ld_data;

    always #10 clk = ~clk;

    txpend_ctrl u_txpend_ctrl (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .pend_mode(pend_mode), .trig_sel(trig_sel), .ld_ready(ld_ready),
        .ld_valid(ld_valid), .ld_data(ld_data), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .irq(irq), .ovf_err(ovf_err),
        .batch_err(batch_err)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    byte unsigned m_q[$];
    int  m_xfer, m_wcnt, m_pend, m_state;
    bit  m_irq, m_ovf, m_berr;

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic model_step(input bit wv, input byte unsigned wd, input bit lr);
        int  b, hold, eff;
        bit  full, empty, push, pop, cond, done;
        b    = int'(trig_sel) + 1;
        hold = 16 / b - 1;
        if (rst) begin
            m_q.delete();
            m_xfer = 0; m_wcnt = 0; m_pend = 0; m_state = 0;
            m_irq = 0; m_ovf = 0; m_berr = 0;
            return;
        end
        full  = (m_q.size() == 16);
        empty = (m_q.size() == 0);
        push  = wv && !full;
        pop   = lr && !empty;
        cond  = pop && (m_xfer == b - 1);
        if (pop) m_xfer = (m_xfer + 1) % b;
        done  = pend_mode && (m_state == 2) && push && (m_wcnt == b - 1);
        if (!pend_mode || m_state != 2) m_wcnt = 0;
        else if (push) m_wcnt = (m_wcnt + 1) % b;
        if (wv && full) m_ovf = 1;
        m_irq = 0;
        if (!pend_mode) begin
            m_irq = cond; m_state = 0; m_pend = 0;
        end else if (m_state != 2) begin
            if (m_state == 1 && push) m_berr = 1;
            if (cond) begin m_irq = 1; m_state = 2; end
        end else if (done) begin
            eff = m_pend + int'(cond);
            if (eff > 0) begin m_irq = 1; m_pend = eff - 1; end
            else m_state = 1;
        end else if (cond && m_pend < hold) begin
            m_pend++;
        end
        if (pop)  void'(m_q.pop_front());
        if (push) m_q.push_back(wd);
    endtask

    // compare current outputs against model, then apply inputs for next edge
    task automatic step(input bit wv, input byte unsigned wd, input bit lr, input string tag);
        @(negedge clk);
        chk(tag, "irq", int'(irq), int'(m_irq));
        chk(tag, "ld_valid", int'(ld_valid), int'(m_q.size() != 0));
        if (m_q.size() != 0) chk(tag, "ld_data", int'(ld_data), int'(m_q[0]));
        chk(tag, "fifo_full", int'(fifo_full), int'(m_q.size() == 16));
        chk(tag, "fifo_empty", int'(fifo_empty), int'(m_q.size() == 0));
        chk(tag, "ovf_err", int'(ovf_err), int'(m_ovf));
        chk(tag, "batch_err", int'(batch_err), int'(m_berr));
        wr_valid = wv; wr_data = wd; ld_ready = lr;
        model_step(wv, wd, lr);
    endtask

    task automatic restart(input bit pm, input logic [3:0] ts, input string tag);
        @(negedge clk);
        rst = 1'b1; pend_mode = pm; trig_sel = ts;
        wr_valid = 0; ld_ready = 0;
        model_step(0, 0, 0);
        step(0, 0, 0, tag);
        rst = 1'b0;
        model_step(0, 0, 0);
        step(0, 0, 0, tag);
    endtask

    initial begin
        #(20ns * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL R10 watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_step(0, 0, 0);
        // R10: reset state, plain mode, 2-byte batch
        restart(1'b0, 4'd1, "R10");
        // R1 R4 R2: six bytes drained, three pulses in plain mode
        for (int i = 0; i < 6; i++) step(1, byte'(8'h10 + i), 0, "R2");
        for (int i = 0; i < 9; i++) step(0, 0, 1, "R1 R4");
        // R3: overfill a 16-byte batch FIFO, then drain it
        restart(1'b0, 4'd15, "R10");
        for (int i = 0; i < 18; i++) step(1, byte'(8'h40 + i), 0, "R3");
        step(1, 8'hEE, 1, "R2");
        for (int i = 0; i < 17; i++) step(0, 0, 1, "R1 R3");
        // R5 R7 R8: 1-byte batches, one full drain, then refills release holds
        restart(1'b1, 4'd0, "R10");
        for (int i = 0; i < 16; i++) step(1, byte'(i), 0, "R5");
        for (int i = 0; i < 16; i++) step(0, 0, 1, "R5 R7 R8");
        for (int i = 0; i < 3; i++)  step(0, 0, 0, "R5");
        for (int i = 0; i < 16; i++) step(1, byte'(8'h80 + i), 0, "R6");
        step(0, 0, 0, "R6");
        step(1, 8'h5A, 0, "R9");
        for (int i = 0; i < 3; i++) step(0, 0, 0, "R9");
        // R7 R6: 9-byte batch, zero hold ceiling drops the late condition
        restart(1'b1, 4'd8, "R10");
        for (int i = 0; i < 16; i++) step(1, byte'(8'hA0 + i), 0, "R7");
        for (int i = 0; i < 16; i++) step(0, 0, 1, "R7");
        for (int i = 0; i < 8; i++)  step(1, byte'(8'hC0 + i), 0, "R6");
        for (int i = 0; i < 2; i++)  step(0, 0, 1, "R7");
        step(1, 8'hCF, 0, "R6");
        for (int i = 0; i < 3; i++)  step(0, 0, 0, "R6 R7");
        // R11: refill completion coinciding with a new condition
        restart(1'b1, 4'd1, "R10");
        for (int i = 0; i < 4; i++) step(1, byte'(8'h20 + i), 0, "R11");
        for (int i = 0; i < 2; i++) step(0, 0, 1, "R11");
        for (int i = 0; i < 2; i++) step(1, byte'(8'h30 + i), 1, "R11");
        for (int i = 0; i < 3; i++) step(0, 0, 0, "R11");
        // mixed random traffic across trigger sizes and modes
        for (int r = 0; r < 12; r++) begin
            restart(1'(r % 3 != 0), 4'($urandom_range(0, 15)), "R10");
            for (int i = 0; i < 300; i++)
                step(1'($urandom_range(0, 1)), byte'($urandom), 1'($urandom_range(0, 1)),
                     "R5 R6 R7 R8 R9 R11 R2 R3");
        end
        step(0, 0, 0, "R10");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule